// File: doc/BRIEF.md
# Split 32/dual-16 bit timer

A memory-mapped timer that owns one 32-bit count register. With the split bit clear it is a single 32-bit timer that runs one-shot, continuous or PWM. With the split bit set the same storage becomes two 16-bit timers. Each 16-bit timer has its own enable, terminal value, repeat mode and interrupt flag. Both modes share one power-of-two prescaler, which divides the clock by 2^N.

Software programs the block through a small register port. It sets terminal, duty and count values, then writes the control word to start counting. The block drives one timer/PWM output pin and one interrupt line. The prescaler code clears itself whenever every timer that uses it is stopped, so it must be written again together with each start.

Top module: `split_timer`

## Requirements
- R1: After reset every register reads zero, and both the output pin and the interrupt line are low.
- R2: With prescale code N (control bits [11:8]), a running counter advances once every 2^N clocks. Starting from count 0 with terminal value T, the first terminal event lands (T+1)·2^N clocks after the start write. A code written above 12 is stored as 12.
- R3: The prescale code reads zero whenever no counter that uses it is enabled. In 32-bit mode only enable 0 (bit 0) counts. In split mode (bit 2 set) the code survives while either enable 0 or enable 1 (bit 1) is set.
- R4: In 32-bit continuous mode (bits [4:3] = 01), a tick that finds the count equal to the terminal value (address 2) sets flag bit 0 and reloads the count to 1, so later events are T·2^N clocks apart. The output pin toggles on every event and starts at the polarity level when enable 0 rises.
- R5: In 32-bit one-shot mode (bits [4:3] = 00), the terminal event sets flag bit 0 and clears enable 0. The count then holds at the terminal value.
- R6: In PWM mode (bits [4:3] = 1x), the count runs 1..T and then restarts at 1. The pin is high while the count is greater than or equal to the duty value (address 3).
- R7: Polarity (bit 5) inverts the pin in 32-bit mode. In split mode the pin is held low.
- R8: In split mode, count bits [15:0] and [31:16] advance independently. The low timer uses enable 0, the terminal value at address 6, continuous bit 6 and flag bit 0. The high timer uses enable 1, the terminal value at address 7, continuous bit 7 and flag bit 1.
- R9: Writing 1 to a bit of the flag register (address 8) clears that flag. An event in the same cycle wins over the clear. The interrupt line is high while any flag is set.
- R10: Writing 0 to the control register (address 0) clears both enables. From then on the counts keep their values.
- R11: The count can be written as 32 bits (address 1) or as its low and high halves (addresses 4 and 5). A write replaces any count step in that cycle, and address 1 reads the concatenation {high, low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tmr_out | output | 1 | Timer / PWM output pin |
| irq | output | 1 | Interrupt, OR of the flags |

## Verification
The 32-bit continuous mode runs from a table of prescale codes and terminal values. The table covers N = 0, intermediate codes and the maximum code of 12, and the smallest periods. Measuring the first and second event distances separates an off-by-one in the reload value from a wrong divider mask. PWM is tracked cycle by cycle against a modelled count, with both polarities, so that the duty compare and the wrap point can be told apart. Split mode uses two different terminal values so the halves run out of phase, which exposes any carry or shared enable between them. Separate tests cover the prescale self-clear in both modes and the one-shot stop.

// File: rtl/stmr_pkg.sv
package stmr_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] A_CNT32  = 4'h1;
    localparam logic [ADDR_W-1:0] A_TERM32 = 4'h2;
    localparam logic [ADDR_W-1:0] A_DUTY   = 4'h3;
    localparam logic [ADDR_W-1:0] A_CNTLO  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CNTHI  = 4'h5;
    localparam logic [ADDR_W-1:0] A_TERMLO = 4'h6;
    localparam logic [ADDR_W-1:0] A_TERMHI = 4'h7;
    localparam logic [ADDR_W-1:0] A_FLAG   = 4'h8;

    localparam int PSC_CODE_W = 4;

    typedef enum logic [1:0] {
        M32_ONESHOT = 2'd0,
        M32_CONT    = 2'd1,
        M32_PWM     = 2'd2,
        M32_PWM_ALT = 2'd3
    } mode32_e;

    // Control word, most significant field first
    typedef struct packed {
        logic [PSC_CODE_W-1:0] psc;
        logic                  cont_hi;
        logic                  cont_lo;
        logic                  pol;
        mode32_e               mode32;
        logic                  split;
        logic                  en1;
        logic                  en0;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/stmr_prescale.sv
module stmr_prescale #(
    parameter int PSC_MAX = 12,
    parameter int CODE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int DIV_W = (PSC_MAX < 1) ? 1 : PSC_MAX;
    localparam logic [DIV_W:0]   ONE_W = 1;
    localparam logic [DIV_W-1:0] ONE_D = 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] mask;

    // mask has N low bits set; a tick fires when they are all ones
    assign span = (ONE_W << code) - ONE_W;
    assign mask = span[DIV_W-1:0];
    assign tick = run && ((div_q & mask) == mask);

    always_comb begin
        div_d = run ? (div_q + ONE_D) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // Divider restarts from zero while every timer is stopped
    assert_div_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_q == '0));

endmodule

// File: rtl/stmr_step.sv
module stmr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] term,
    output logic         hit,
    output logic [W-1:0] inc
);
    assign hit = (cnt == term);
    assign inc = cnt + W'(1);
endmodule

// File: rtl/split_timer.sv
module split_timer
    import stmr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PSC_MAX = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tmr_out,
    output logic              irq
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [HALF_W-1:0]     HALF_ONE = 1;
    localparam logic [DATA_W-1:0]     FULL_ONE = 1;
    localparam logic [PSC_CODE_W-1:0] PSC_LIM  = PSC_CODE_W'(PSC_MAX);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] term32;
        logic [DATA_W-1:0] duty;
        logic [HALF_W-1:0] term_lo;
        logic [HALF_W-1:0] term_hi;
        logic [1:0]        flag;
        logic              tog;
    } state_t;

    state_t s_d, s_q;

    logic                   tick;
    logic                   run_q;
    logic                   run_d;
    logic                   hit32;
    logic [DATA_W-1:0]      inc32;
    logic [1:0]             half_hit;
    logic [1:0][HALF_W-1:0] half_inc;
    logic [1:0]             half_en;
    logic [1:0]             half_cont;
    logic [1:0]             flag_set;
    logic [1:0]             flag_clr;
    logic                   is_pwm;
    ctrl_t                  wr_ctrl;

    assign run_q     = s_q.ctrl.split ? (s_q.ctrl.en0 | s_q.ctrl.en1) : s_q.ctrl.en0;
    assign half_en   = {s_q.ctrl.en1, s_q.ctrl.en0};
    assign half_cont = {s_q.ctrl.cont_hi, s_q.ctrl.cont_lo};
    assign is_pwm    = (s_q.ctrl.mode32 == M32_PWM) || (s_q.ctrl.mode32 == M32_PWM_ALT);

    stmr_prescale #(.PSC_MAX(PSC_MAX), .CODE_W(PSC_CODE_W)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run_q),
        .code (s_q.ctrl.psc),
        .tick (tick)
    );

    stmr_step #(.W(DATA_W)) u_step32 (
        .cnt (s_q.cnt),
        .term(s_q.term32),
        .hit (hit32),
        .inc (inc32)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        stmr_step #(.W(HALF_W)) u_step (
            .cnt (s_q.cnt[h*HALF_W +: HALF_W]),
            .term((h == 0) ? s_q.term_lo : s_q.term_hi),
            .hit (half_hit[h]),
            .inc (half_inc[h])
        );
    end

    // Next-state logic
    always_comb begin
        s_d      = s_q;
        flag_set = '0;
        flag_clr = '0;
        wr_ctrl  = ctrl_t'(wdata[CTRL_W-1:0]);
        run_d    = 1'b0;

        // Counting
        if (s_q.ctrl.split) begin
            for (int h = 0; h < 2; h++) begin
                if (tick && half_en[h]) begin
                    if (half_hit[h]) begin
                        flag_set[h] = 1'b1;
                        if (half_cont[h]) begin
                            s_d.cnt[h*HALF_W +: HALF_W] = HALF_ONE;
                        end else if (h == 0) begin
                            s_d.ctrl.en0 = 1'b0;
                        end else begin
                            s_d.ctrl.en1 = 1'b0;
                        end
                    end else begin
                        s_d.cnt[h*HALF_W +: HALF_W] = half_inc[h];
                    end
                end
            end
        end else if (tick && s_q.ctrl.en0) begin
            if (hit32) begin
                flag_set[0] = 1'b1;
                if (!is_pwm) s_d.tog = ~s_q.tog;
                if (s_q.ctrl.mode32 == M32_ONESHOT) s_d.ctrl.en0 = 1'b0;
                else                                s_d.cnt      = FULL_ONE;
            end else begin
                s_d.cnt = inc32;
            end
        end

        // Register writes take priority over counting
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    if (wr_ctrl.psc > PSC_LIM) wr_ctrl.psc = PSC_LIM;
                    if (wr_ctrl.en0 && !s_q.ctrl.en0) s_d.tog = 1'b0;
                    s_d.ctrl = wr_ctrl;
                end
                A_CNT32:  s_d.cnt = wdata;
                A_CNTLO:  s_d.cnt[HALF_W-1:0] = wdata[HALF_W-1:0];
                A_CNTHI:  s_d.cnt[DATA_W-1:HALF_W] = wdata[HALF_W-1:0];
                A_TERM32: s_d.term32 = wdata;
                A_DUTY:   s_d.duty = wdata;
                A_TERMLO: s_d.term_lo = wdata[HALF_W-1:0];
                A_TERMHI: s_d.term_hi = wdata[HALF_W-1:0];
                A_FLAG:   flag_clr = wdata[1:0];
                default:  ;
            endcase
        end

        s_d.flag = (s_q.flag & ~flag_clr) | flag_set;

        // Prescale code self-clears once no user of it is enabled
        run_d = s_d.ctrl.split ? (s_d.ctrl.en0 | s_d.ctrl.en1) : s_d.ctrl.en0;
        if (!run_d) s_d.ctrl.psc = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Read mux
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata[CTRL_W-1:0] = s_q.ctrl;
            A_CNT32:  rdata = s_q.cnt;
            A_TERM32: rdata = s_q.term32;
            A_DUTY:   rdata = s_q.duty;
            A_CNTLO:  rdata[HALF_W-1:0] = s_q.cnt[HALF_W-1:0];
            A_CNTHI:  rdata[HALF_W-1:0] = s_q.cnt[DATA_W-1:HALF_W];
            A_TERMLO: rdata[HALF_W-1:0] = s_q.term_lo;
            A_TERMHI: rdata[HALF_W-1:0] = s_q.term_hi;
            A_FLAG:   rdata[1:0] = s_q.flag;
            default:  rdata = '0;
        endcase
    end

    // Output pin
    always_comb begin
        if (s_q.ctrl.split)  tmr_out = 1'b0;
        else if (is_pwm)     tmr_out = s_q.ctrl.pol ^ (s_q.cnt >= s_q.duty);
        else                 tmr_out = s_q.ctrl.pol ^ s_q.tog;
    end

    assign irq = |s_q.flag;

    assert_psc_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ctrl.psc <= PSC_LIM);

    assert_psc_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (s_q.ctrl.psc == '0));

    assert_reload_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.split && s_q.ctrl.en0 && s_q.ctrl.mode32 != M32_ONESHOT
         && tick && hit32 && !wr_en) |=> (s_q.cnt == FULL_ONE));

    assert_oneshot_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.split && s_q.ctrl.en0 && s_q.ctrl.mode32 == M32_ONESHOT
         && tick && hit32 && !wr_en) |=> !s_q.ctrl.en0);

    assert_split_pin_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ctrl.split |-> !tmr_out);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_FLAG && wdata[1] && !s_q.ctrl.split) |=> !s_q.flag[1]);

    assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_en) |=> $stable(s_q.cnt));

endmodule

// File: tb/split_timer_test.sv
module split_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // Stimulus/expected table: prescale code, terminal value, first-event latency
    localparam int VEC_N   [NVEC] = '{0, 1, 2, 3, 0, 4, 12};
    localparam int VEC_T   [NVEC] = '{5, 5, 3, 7, 2, 2, 1};
    localparam int VEC_LAT [NVEC] = '{6, 12, 16, 64, 3, 48, 8192};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tmr_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    split_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        while (!irq && k < 20000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int k;
        int model;

        #(CLK_PERIOD * 2 + 2);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a <= 8; a++) begin
            rd(4'(a), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset pin", {31'b0, tmr_out}, 32'h0);
        chk("R1 reset irq", {31'b0, irq}, 32'h0);

        // R11 count access by halves
        wr(4'h1, 32'h1234_5678);
        rd(4'h4, v); chk("R11 low half", v, 32'h5678);
        rd(4'h5, v); chk("R11 high half", v, 32'h1234);
        wr(4'h5, 32'h0000_ABCD);
        rd(4'h1, v); chk("R11 concat", v, 32'hABCD_5678);

        // R2 prescale saturation
        wr(4'h0, 32'h0000_0F01);
        rd(4'h0, v); chk("R2 code clamp", v, 32'h0000_0C01);
        wr(4'h0, 32'h0);
        // R3 code cleared when written with no enable
        wr(4'h0, 32'h0000_0500);
        rd(4'h0, v); chk("R3 idle write", v, 32'h0);

        // R4/R2 continuous table
        for (int i = 0; i < NVEC; i++) begin
            wr(4'h0, 32'h0);
            wr(4'h8, 32'h3);
            wr(4'h1, 32'h0);
            wr(4'h2, 32'(VEC_T[i]));
            wr(4'h0, 32'h0000_0009 | (32'(VEC_N[i]) << 8));
            chk("R4 pin at start", {31'b0, tmr_out}, 32'h0);
            wait_irq(k);
            chk("R2 first event latency", 32'(k), 32'(VEC_LAT[i]));
            chk("R4 pin toggled", {31'b0, tmr_out}, 32'h1);
            rd(4'h1, v); chk("R4 reload to one", v, 32'h1);
            wr(4'h8, 32'h1);   // write lands 2 clocks after the event; equal time => R9 set wins
            wait_irq(k);
            chk("R4 period", 32'(k), 32'((VEC_T[i] << VEC_N[i]) - 2));
            chk("R4 pin toggled back", {31'b0, tmr_out}, 32'h0);
        end
        wr(4'h0, 32'h0);
        wr(4'h8, 32'h3);

        // R5 one-shot with N=2, T=4
        wr(4'h1, 32'h0);
        wr(4'h2, 32'h4);
        wr(4'h0, 32'h0000_0201);
        wait_irq(k);
        chk("R5 one-shot latency", 32'(k), 32'd20);
        rd(4'h0, v); chk("R5 enable cleared and R3 code cleared", v, 32'h0);
        repeat (8) @(negedge clk);
        rd(4'h1, v); chk("R5 count holds at terminal", v, 32'h4);
        wr(4'h8, 32'h3);

        // R6 PWM, T=8, duty=3, polarity 0
        wr(4'h1, 32'h0);
        wr(4'h2, 32'h8);
        wr(4'h3, 32'h3);
        wr(4'h0, 32'h0000_0011);
        model = 0;
        for (int c = 0; c < 20; c++) begin
            rd(4'h1, v);
            chk("R6 pwm count", v, 32'(model));
            chk("R6 pwm pin", {31'b0, tmr_out}, (model >= 3) ? 32'h1 : 32'h0);
            @(negedge clk);
            model = (model == 8) ? 1 : model + 1;
        end
        // R7 polarity
        wr(4'h0, 32'h0);
        wr(4'h1, 32'h0);
        wr(4'h0, 32'h0000_0031);
        chk("R7 inverted low count", {31'b0, tmr_out}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R7 inverted at duty", {31'b0, tmr_out}, 32'h0);
        wr(4'h0, 32'h0);
        wr(4'h8, 32'h3);

        // R8 split continuous halves, lo term 3, hi term 5; R7 pin low
        wr(4'h1, 32'h0);
        wr(4'h6, 32'h3);
        wr(4'h7, 32'h5);
        wr(4'h0, 32'h0000_00E7);
        repeat (4) @(negedge clk);
        rd(4'h8, v); chk("R8 low flag first", v, 32'h1);
        repeat (2) @(negedge clk);
        rd(4'h8, v); chk("R8 both flags", v, 32'h3);
        rd(4'h1, v); chk("R8 independent halves", v, 32'h0001_0003);
        chk("R7 split pin low", {31'b0, tmr_out}, 32'h0);

        // R10 stop holds counts
        wr(4'h0, 32'h0);
        rd(4'h1, v);
        repeat (5) @(negedge clk);
        rd(4'h1, v2); chk("R10 counts held", v2, v);
        rd(4'h0, v2); chk("R10 control cleared", v2, 32'h0);

        // R9 write-one-to-clear
        wr(4'h8, 32'h1);
        rd(4'h8, v); chk("R9 clear low flag only", v, 32'h2);
        chk("R9 irq with one flag", {31'b0, irq}, 32'h1);
        wr(4'h8, 32'h2);
        rd(4'h8, v); chk("R9 all clear", v, 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'h0);

        // R3 split: code kept while high half runs
        wr(4'h1, 32'h0);
        wr(4'h6, 32'h2);
        wr(4'h7, 32'hFFFF);
        wr(4'h0, 32'h0000_0307);
        wait_irq(k);
        chk("R3 split low one-shot latency", 32'(k), 32'd24);
        rd(4'h0, v); chk("R3 code kept in split", v, 32'h0000_0306);
        wr(4'h0, 32'h0000_0302);
        rd(4'h0, v); chk("R3 32-bit ignores enable 1", v, 32'h0000_0002);
        wr(4'h0, 32'h0);
        wr(4'h8, 32'h3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule